// File: doc/BRIEF.md
# Data-Flash Command Error Guard

This block sits beside the command interface of an embedded data-flash controller. On each command cycle it looks at the decoded command, its argument byte and its target area. It weighs these against the current entry modes (data-area P/E entry, code-area P/E entry) and the data-area read and write protection settings. A command that passes is forwarded as a one-cycle grant pulse: `pe_go` for a program, erase or lock-bit program, `rd_go` for a read, `susp_go` for a suspend. A command that fails sets one or more sticky error flags and puts the interface into a command-locked state.

While locked, the guard refuses every new command, a P/E suspend included. A program or erase that is already running is never aborted, so it runs to completion. The only way out is a status-clear command. It is honoured only when the access-status word shows the lock bit alone. Software first clears the per-cause flags by writing zeros to them. A four-bit enable word gates the rising edges of the lock flag and the three per-cause flags onto one error interrupt.

Top module: `dflash_errguard`

## Requirements
- R1: After reset, `astat`, `ien`, `ill_err`, `cmd_lock`, `err_irq` and all grant pulses are 0.
- R2: A program command (`cmd_op`=1) whose argument byte is neither 0x04 nor 0x40 sets `ill_err` and `cmd_lock`, leaves the per-cause flags clear, and gives no grant.
- R3: A lock-bit program command (`cmd_op`=3) aimed at the data area while data-area P/E entry is set sets `ill_err` and `cmd_lock` only.
- R4: An access error sets `ill_err`, the access flag (`astat` bit 3) and `cmd_lock`. It happens when a command targets the data area and any of these holds: code-area P/E entry is set; it is a read (`cmd_op`=0) with data-area entry set; it is a write-class command (`cmd_op` 1, 2 or 3) with data-area entry clear.
- R5: A read of the data area under read protection, with no access error, sets `ill_err`, the read-protect flag (`astat` bit 1) and `cmd_lock`.
- R6: A program or block erase (`cmd_op` 1 or 2) to the data area under write protection, with no prior error, sets `ill_err`, the write-protect flag (`astat` bit 0) and `cmd_lock`.
- R7: While locked, every command sets `ill_err` and produces no grant pulse, except a release that satisfies R8.
- R8: A status-clear command (`cmd_op`=5) releases the lock and clears `ill_err` only when `astat` equals 0x10 (lock bit 4 alone). Under any other `astat` value it counts as an illegal command.
- R9: A software write to `astat` clears each per-cause flag whose data bit is 0. Data bits of 1 leave the flags unchanged, and the write never changes `cmd_lock`.
- R10: `err_irq` is a one-cycle pulse in the cycle after an edge in which an enabled flag rises. Enable bits are 0 lock, 1 access, 2 read-protect, 3 write-protect, and a new enable value takes effect from the next cycle. A flag that stays high does not retrigger the pulse.
- R11: An accepted command produces its grant one cycle later. Program, erase and lock-bit program give `pe_go`, and a read gives `rd_go`. A suspend (`cmd_op`=4) gives `susp_go` only while `pe_busy` is high.
- R12: Checks run in a fixed priority: the access error first, then the lock-bit rule, then the program argument, then read protection, then write protection. Only the first failing check sets its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code: 0 read, 1 program, 2 block erase, 3 lock-bit program, 4 suspend, 5 status clear, 6/7 other |
| cmd_arg | input | 8 | Second-cycle byte of a program command |
| cmd_to_data | input | 1 | Command targets the data area |
| dp_entry | input | 1 | Data-area P/E entry mode |
| cp_entry | input | 1 | Code-area P/E entry mode |
| rd_prot | input | 1 | Data-area read protection active |
| wr_prot | input | 1 | Data-area program/erase protection active |
| pe_busy | input | 1 | A program or erase is in progress |
| astat_we | input | 1 | Software write strobe for the access-status word |
| astat_wdata | input | 8 | Software write data for the access-status word |
| ien_we | input | 1 | Software write strobe for the interrupt enables |
| ien_wdata | input | 4 | Interrupt enable write data |
| astat | output | 8 | Access status: bit 4 lock, bit 3 access error, bit 1 read-protect, bit 0 write-protect |
| ien | output | 4 | Interrupt enables in force |
| ill_err | output | 1 | Illegal-command flag |
| cmd_lock | output | 1 | Command-locked state |
| pe_go | output | 1 | Grant pulse for program/erase/lock-bit program |
| rd_go | output | 1 | Grant pulse for read |
| susp_go | output | 1 | Grant pulse for suspend |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
The assertions hold several rules on every cycle. No grant appears for a command issued while locked, and such a command raises the illegal flag. The lock falls only one cycle after a status-clear seen with `astat` at 0x10, and it never moves without a command. Each per-cause flag rises only together with the illegal flag and the lock. The interrupt is single-cycle and is traceable to an enabled flag edge. The check priority, the no-effect of written ones, the release refused under a non-0x10 status, and the enable timing are only shown by the bench. It runs scenarios that combine mode settings and then recovers through the clear-and-release sequence.

// File: rtl/dfeg_pkg.sv
package dfeg_pkg;

    localparam int OP_W  = 3;
    localparam int ST_W  = 8;
    localparam int EN_W  = 4;
    localparam int ARG_W = 8;

    // bit positions inside the access-status word
    localparam int BIT_WPE  = 0;
    localparam int BIT_RPE  = 1;
    localparam int BIT_ACC  = 3;
    localparam int BIT_LOCK = 4;

    // bit positions inside the interrupt-enable word
    localparam int EN_LOCK = 0;
    localparam int EN_ACC  = 1;
    localparam int EN_RPE  = 2;
    localparam int EN_WPE  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_READ    = 3'd0,
        OP_PROG    = 3'd1,
        OP_ERASE   = 3'd2,
        OP_LOCKBIT = 3'd3,
        OP_SUSPEND = 3'd4,
        OP_STCLR   = 3'd5,
        OP_MISC6   = 3'd6,
        OP_MISC7   = 3'd7
    } op_e;

    // outcome of checking one command
    typedef struct packed {
        logic ill;
        logic acc;
        logic rpe;
        logic wpe;
        logic go_pe;
        logic go_rd;
        logic go_susp;
        logic rel_lk;
        logic clr_ill;
    } verdict_t;

    // registered state of the guard
    typedef struct packed {
        logic            lock;
        logic            ill;
        logic            acc;
        logic            rpe;
        logic            wpe;
        logic [EN_W-1:0] ien;
        logic            go_pe;
        logic            go_rd;
        logic            go_susp;
    } st_t;

endpackage

// File: rtl/dfeg_classify.sv
module dfeg_classify
    import dfeg_pkg::*;
#(
    parameter logic [ARG_W-1:0] PGM_CODE_A = 8'h04,
    parameter logic [ARG_W-1:0] PGM_CODE_B = 8'h40
) (
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             cmd_to_data,
    input  logic             dp_entry,
    input  logic             cp_entry,
    input  logic             rd_prot,
    input  logic             wr_prot,
    input  logic             pe_busy,
    input  logic             locked,
    input  logic             stat_is_release,
    output verdict_t         v
);

    logic is_rd;
    logic is_pe;
    logic is_wr;
    logic acc_hit;
    logic lbp_hit;
    logic arg_bad;
    logic rpe_hit;
    logic wpe_hit;

    always_comb begin
        is_rd   = (cmd_op == OP_READ);
        is_pe   = (cmd_op == OP_PROG) || (cmd_op == OP_ERASE);
        is_wr   = is_pe || (cmd_op == OP_LOCKBIT);
        acc_hit = cmd_to_data && (cp_entry || (is_rd && dp_entry) || (is_wr && !dp_entry));
        lbp_hit = (cmd_op == OP_LOCKBIT) && cmd_to_data && dp_entry;
        arg_bad = (cmd_op == OP_PROG) && (cmd_arg != PGM_CODE_A) && (cmd_arg != PGM_CODE_B);
        rpe_hit = is_rd && cmd_to_data && rd_prot;
        wpe_hit = is_pe && cmd_to_data && wr_prot;
    end

    always_comb begin
        v = '0;
        if (cmd_valid) begin
            if (locked) begin
                if ((cmd_op == OP_STCLR) && stat_is_release) begin
                    v.rel_lk = 1'b1;
                end else begin
                    v.ill = 1'b1;
                end
            end else if (acc_hit) begin
                v.ill = 1'b1;
                v.acc = 1'b1;
            end else if (lbp_hit || arg_bad) begin
                v.ill = 1'b1;
            end else if (rpe_hit) begin
                v.ill = 1'b1;
                v.rpe = 1'b1;
            end else if (wpe_hit) begin
                v.ill = 1'b1;
                v.wpe = 1'b1;
            end else begin
                v.go_pe   = is_wr;
                v.go_rd   = is_rd;
                v.go_susp = (cmd_op == OP_SUSPEND) && pe_busy;
                v.clr_ill = (cmd_op == OP_STCLR);
            end
        end
    end

endmodule

// File: rtl/dfeg_state.sv
module dfeg_state
    import dfeg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  verdict_t        v,
    input  logic            astat_we,
    input  logic [ST_W-1:0] astat_wdata,
    input  logic            ien_we,
    input  logic [EN_W-1:0] ien_wdata,
    output st_t             q,
    output logic [EN_W-1:0] cause_q,
    output logic [EN_W-1:0] cause_d
);

    st_t st_d;
    st_t st_q;

    logic unused_wbits;
    assign unused_wbits = ^astat_wdata;

    always_comb begin
        st_d         = st_q;
        st_d.go_pe   = v.go_pe;
        st_d.go_rd   = v.go_rd;
        st_d.go_susp = v.go_susp;

        if (ien_we) begin
            st_d.ien = ien_wdata;
        end

        // software may only clear the per-cause flags
        if (astat_we) begin
            st_d.acc = st_q.acc & astat_wdata[BIT_ACC];
            st_d.rpe = st_q.rpe & astat_wdata[BIT_RPE];
            st_d.wpe = st_q.wpe & astat_wdata[BIT_WPE];
        end

        // a new error wins over a same-cycle clear
        st_d.acc = st_d.acc | v.acc;
        st_d.rpe = st_d.rpe | v.rpe;
        st_d.wpe = st_d.wpe | v.wpe;

        if (v.rel_lk) begin
            st_d.lock = 1'b0;
            st_d.ill  = 1'b0;
        end else begin
            if (v.ill) begin
                st_d.lock = 1'b1;
                st_d.ill  = 1'b1;
            end
            if (v.clr_ill) begin
                st_d.ill = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        q                = st_q;
        cause_q          = '0;
        cause_q[EN_LOCK] = st_q.lock;
        cause_q[EN_ACC]  = st_q.acc;
        cause_q[EN_RPE]  = st_q.rpe;
        cause_q[EN_WPE]  = st_q.wpe;
        cause_d          = '0;
        cause_d[EN_LOCK] = st_d.lock;
        cause_d[EN_ACC]  = st_d.acc;
        cause_d[EN_RPE]  = st_d.rpe;
        cause_d[EN_WPE]  = st_d.wpe;
    end

endmodule

// File: rtl/dfeg_irq.sv
module dfeg_irq
    import dfeg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EN_W-1:0] cause_q,
    input  logic [EN_W-1:0] cause_d,
    input  logic [EN_W-1:0] en_q,
    output logic            irq
);

    typedef struct packed {
        logic pulse;
    } irq_st_t;

    irq_st_t irq_d;
    irq_st_t irq_q;
    logic [EN_W-1:0] rise;

    always_comb begin
        rise        = cause_d & ~cause_q;
        irq_d.pulse = |(rise & en_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q.pulse;

endmodule

// File: rtl/dflash_errguard.sv
module dflash_errguard
    import dfeg_pkg::*;
#(
    parameter logic [ARG_W-1:0] PGM_CODE_A = 8'h04,
    parameter logic [ARG_W-1:0] PGM_CODE_B = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             cmd_to_data,
    input  logic             dp_entry,
    input  logic             cp_entry,
    input  logic             rd_prot,
    input  logic             wr_prot,
    input  logic             pe_busy,
    input  logic             astat_we,
    input  logic [ST_W-1:0]  astat_wdata,
    input  logic             ien_we,
    input  logic [EN_W-1:0]  ien_wdata,
    output logic [ST_W-1:0]  astat,
    output logic [EN_W-1:0]  ien,
    output logic             ill_err,
    output logic             cmd_lock,
    output logic             pe_go,
    output logic             rd_go,
    output logic             susp_go,
    output logic             err_irq
);

    localparam logic [ST_W-1:0] RELEASE_VAL = ST_W'(1) << BIT_LOCK;

    verdict_t        verdict;
    st_t             st;
    logic [EN_W-1:0] cause_q;
    logic [EN_W-1:0] cause_d;
    logic [ST_W-1:0] stat_word;
    logic            stat_is_release;

    always_comb begin
        stat_word           = '0;
        stat_word[BIT_LOCK] = st.lock;
        stat_word[BIT_ACC]  = st.acc;
        stat_word[BIT_RPE]  = st.rpe;
        stat_word[BIT_WPE]  = st.wpe;
        stat_is_release     = (stat_word == RELEASE_VAL);
    end

    dfeg_classify #(
        .PGM_CODE_A (PGM_CODE_A),
        .PGM_CODE_B (PGM_CODE_B)
    ) u_classify (
        .cmd_valid       (cmd_valid),
        .cmd_op          (cmd_op),
        .cmd_arg         (cmd_arg),
        .cmd_to_data     (cmd_to_data),
        .dp_entry        (dp_entry),
        .cp_entry        (cp_entry),
        .rd_prot         (rd_prot),
        .wr_prot         (wr_prot),
        .pe_busy         (pe_busy),
        .locked          (st.lock),
        .stat_is_release (stat_is_release),
        .v               (verdict)
    );

    dfeg_state u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .v           (verdict),
        .astat_we    (astat_we),
        .astat_wdata (astat_wdata),
        .ien_we      (ien_we),
        .ien_wdata   (ien_wdata),
        .q           (st),
        .cause_q     (cause_q),
        .cause_d     (cause_d)
    );

    dfeg_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_q (cause_q),
        .cause_d (cause_d),
        .en_q    (st.ien),
        .irq     (err_irq)
    );

    assign astat    = stat_word;
    assign ien      = st.ien;
    assign ill_err  = st.ill;
    assign cmd_lock = st.lock;
    assign pe_go    = st.go_pe;
    assign rd_go    = st.go_rd;
    assign susp_go  = st.go_susp;

endmodule

// File: rtl/dfeg_checker.sv
module dfeg_checker
    import dfeg_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            pe_busy,
    input logic [ST_W-1:0] astat,
    input logic [EN_W-1:0] ien,
    input logic            ill_err,
    input logic            cmd_lock,
    input logic            pe_go,
    input logic            rd_go,
    input logic            susp_go,
    input logic            err_irq
);

    p_locked_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lock && cmd_valid) |=> (!pe_go && !rd_go && !susp_go));

    p_locked_sets_ill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lock && cmd_valid && !(cmd_op == OP_STCLR && astat == 8'h10)) |=> ill_err);

    p_release_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_lock) |-> $past(cmd_valid && cmd_op == OP_STCLR && astat == 8'h10));

    p_lock_needs_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(cmd_lock));

    p_acc_with_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(astat[BIT_ACC]) |-> (ill_err && cmd_lock));

    p_rpe_with_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(astat[BIT_RPE]) |-> (ill_err && cmd_lock));

    p_wpe_with_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(astat[BIT_WPE]) |-> (ill_err && cmd_lock));

    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> |($past(ien) & {$rose(astat[BIT_WPE]), $rose(astat[BIT_RPE]),
                                    $rose(astat[BIT_ACC]), $rose(astat[BIT_LOCK])}));

    p_susp_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        susp_go |-> $past(pe_busy));

    p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pe_go, rd_go, susp_go}));

endmodule

bind dflash_errguard dfeg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .pe_busy   (pe_busy),
    .astat     (astat),
    .ien       (ien),
    .ill_err   (ill_err),
    .cmd_lock  (cmd_lock),
    .pe_go     (pe_go),
    .rd_go     (rd_go),
    .susp_go   (susp_go),
    .err_irq   (err_irq)
);

// File: tb/sim_dflash_errguard.sv
`timescale 1ns/1ps
module sim_dflash_errguard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_arg = '0;
    logic       cmd_to_data = 1'b0;
    logic       dp_entry = 1'b0;
    logic       cp_entry = 1'b0;
    logic       rd_prot = 1'b0;
    logic       wr_prot = 1'b0;
    logic       pe_busy = 1'b0;
    logic       astat_we = 1'b0;
    logic [7:0] astat_wdata = '0;
    logic       ien_we = 1'b0;
    logic [3:0] ien_wdata = '0;
    logic [7:0] astat;
    logic [3:0] ien;
    logic       ill_err, cmd_lock, pe_go, rd_go, susp_go, err_irq;

    always #2.5 clk = ~clk;

    dflash_errguard u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_to_data(cmd_to_data), .dp_entry(dp_entry),
        .cp_entry(cp_entry), .rd_prot(rd_prot), .wr_prot(wr_prot), .pe_busy(pe_busy),
        .astat_we(astat_we), .astat_wdata(astat_wdata), .ien_we(ien_we),
        .ien_wdata(ien_wdata), .astat(astat), .ien(ien), .ill_err(ill_err),
        .cmd_lock(cmd_lock), .pe_go(pe_go), .rd_go(rd_go), .susp_go(susp_go),
        .err_irq(err_irq)
    );

    int total = 0;
    int bad = 0;

    // expected word: {astat, ien, ill, lock, pe_go, rd_go, susp_go, irq}
    logic [17:0] exp_q[$];
    string       req_q[$];

    // model state and the mode settings for the next step
    logic       m_lock = 0, m_ill = 0, m_acc = 0, m_rpe = 0, m_wpe = 0;
    logic [3:0] m_en = '0;
    logic       n_dpe = 0, n_cpe = 0, n_rdp = 0, n_wrp = 0, n_busy = 0;

    task automatic step(input logic v, input logic [2:0] op, input logic [7:0] arg,
                        input logic td, input logic awe, input logic [7:0] awd,
                        input logic iwe, input logic [3:0] iwd, input string req);
        logic [7:0] st_now;
        logic e_ill, e_acc, e_rpe, e_wpe, g_pe, g_rd, g_su, rel, clr;
        logic is_rd, is_pe, is_wr;
        logic n_lock, n_ill, n_acc, n_rpe, n_wpe, irq;
        logic [3:0] rise;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_arg = arg; cmd_to_data = td;
        astat_we = awe; astat_wdata = awd; ien_we = iwe; ien_wdata = iwd;
        dp_entry = n_dpe; cp_entry = n_cpe; rd_prot = n_rdp; wr_prot = n_wrp; pe_busy = n_busy;
        st_now = {3'b000, m_lock, m_acc, 1'b0, m_rpe, m_wpe};
        {e_ill, e_acc, e_rpe, e_wpe, g_pe, g_rd, g_su, rel, clr} = '0;
        is_rd = (op == 3'd0);
        is_pe = (op == 3'd1) || (op == 3'd2);
        is_wr = is_pe || (op == 3'd3);
        if (v) begin
            if (m_lock) begin
                if (op == 3'd5 && st_now == 8'h10) rel = 1; else e_ill = 1;
            end else if (td && (n_cpe || (is_rd && n_dpe) || (is_wr && !n_dpe))) begin
                e_ill = 1; e_acc = 1;
            end else if (op == 3'd3 && td && n_dpe) begin
                e_ill = 1;
            end else if (op == 3'd1 && arg != 8'h04 && arg != 8'h40) begin
                e_ill = 1;
            end else if (is_rd && td && n_rdp) begin
                e_ill = 1; e_rpe = 1;
            end else if (is_pe && td && n_wrp) begin
                e_ill = 1; e_wpe = 1;
            end else begin
                g_pe = is_wr; g_rd = is_rd; g_su = (op == 3'd4) && n_busy; clr = (op == 3'd5);
            end
        end
        n_acc = (awe ? (m_acc & awd[3]) : m_acc) | e_acc;
        n_rpe = (awe ? (m_rpe & awd[1]) : m_rpe) | e_rpe;
        n_wpe = (awe ? (m_wpe & awd[0]) : m_wpe) | e_wpe;
        n_lock = rel ? 1'b0 : (m_lock | e_ill);
        n_ill  = rel ? 1'b0 : (clr ? 1'b0 : (m_ill | e_ill));
        rise = {n_wpe & ~m_wpe, n_rpe & ~m_rpe, n_acc & ~m_acc, n_lock & ~m_lock};
        irq = |(rise & m_en);
        m_lock = n_lock; m_ill = n_ill; m_acc = n_acc; m_rpe = n_rpe; m_wpe = n_wpe;
        if (iwe) m_en = iwd;
        exp_q.push_back({3'b000, m_lock, m_acc, 1'b0, m_rpe, m_wpe, m_en,
                         m_ill, m_lock, g_pe, g_rd, g_su, irq});
        req_q.push_back(req);
    endtask

    task automatic idle(input string req);
        step(0, 3'd0, 8'h00, 0, 0, 8'h00, 0, 4'h0, req);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] arg, input logic td, input string req);
        step(1, op, arg, td, 0, 8'h00, 0, 4'h0, req);
    endtask

    task automatic swst(input logic [7:0] d, input string req);
        step(0, 3'd0, 8'h00, 0, 1, d, 0, 4'h0, req);
    endtask

    task automatic swen(input logic [3:0] d, input string req);
        step(0, 3'd0, 8'h00, 0, 0, 8'h00, 1, d, req);
    endtask

    task automatic recover(input string req);
        swst(8'h00, req);
        cmd(3'd5, 8'h00, 0, req);
        idle(req);
    endtask

    task automatic modes(input logic dpe, input logic cpe, input logic rdp, input logic wrp, input logic busy);
        n_dpe = dpe; n_cpe = cpe; n_rdp = rdp; n_wrp = wrp; n_busy = busy;
    endtask

    // monitor: compare one expected item per clock, just after the edge
    always begin
        logic [17:0] e, a;
        string r;
        @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            a = {astat, ien, ill_err, cmd_lock, pe_go, rd_go, susp_go, err_irq};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h (astat,ien,ill,lock,pe,rd,su,irq)", r, a, e);
            end
        end
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        idle("R1 reset state");
        swen(4'hF, "R10 enable all");
        // accepted commands
        modes(1, 0, 0, 0, 0);
        cmd(3'd1, 8'h04, 1, "R11 program 0x04 granted");
        cmd(3'd1, 8'h40, 1, "R11 program 0x40 granted");
        cmd(3'd2, 8'h00, 1, "R11 erase granted");
        cmd(3'd0, 8'h00, 0, "R11 code-area read granted");
        modes(1, 0, 0, 0, 1);
        cmd(3'd4, 8'h00, 0, "R11 suspend while busy");
        modes(1, 0, 0, 0, 0);
        cmd(3'd4, 8'h00, 0, "R11 suspend while idle");
        // bad program argument, then locked behaviour
        cmd(3'd1, 8'h14, 1, "R2 bad program argument");
        idle("R10 no retrigger");
        modes(1, 0, 0, 0, 1);
        cmd(3'd1, 8'h04, 1, "R7 program refused while locked");
        cmd(3'd4, 8'h00, 0, "R7 suspend refused while locked");
        swst(8'hFF, "R9 write ones no effect");
        cmd(3'd5, 8'h00, 0, "R8 release at 0x10");
        idle("R8 after release");
        // access errors
        modes(1, 0, 0, 0, 0);
        cmd(3'd0, 8'h00, 1, "R4 read with data entry");
        cmd(3'd5, 8'h00, 0, "R8 release refused at 0x18");
        swst(8'hFF, "R9 ones keep access flag");
        swst(8'h00, "R9 zero clears flag, lock stays");
        cmd(3'd5, 8'h00, 0, "R8 release after clear");
        modes(0, 0, 0, 0, 0);
        cmd(3'd2, 8'h00, 1, "R4 erase without data entry");
        recover("R8 recover");
        modes(1, 1, 1, 1, 0);
        cmd(3'd1, 8'h04, 1, "R12 code entry beats protection");
        recover("R8 recover");
        // protection errors and lock-bit rule
        modes(0, 0, 1, 0, 0);
        cmd(3'd0, 8'h00, 1, "R5 read under read protect");
        recover("R8 recover");
        modes(1, 0, 0, 1, 0);
        cmd(3'd2, 8'h00, 1, "R6 erase under write protect");
        recover("R8 recover");
        modes(1, 0, 0, 1, 0);
        cmd(3'd1, 8'h22, 1, "R12 argument beats write protect");
        recover("R8 recover");
        modes(1, 0, 0, 0, 0);
        cmd(3'd3, 8'h00, 1, "R3 lock-bit program with data entry");
        recover("R8 recover");
        // interrupt gating: only the access-error enable
        swen(4'h2, "R10 access enable only");
        modes(0, 0, 1, 0, 0);
        cmd(3'd0, 8'h00, 1, "R10 read-protect not enabled");
        recover("R8 recover");
        modes(1, 0, 0, 0, 0);
        cmd(3'd0, 8'h00, 1, "R10 access enabled fires");
        idle("R10 single pulse");
        recover("R8 recover");
        swen(4'h0, "R10 all disabled");
        cmd(3'd7, 8'h00, 0, "R11 other command accepted");
        idle("R1 quiet end");
        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 items left", exp_q.size());
        end
        finish_up();
    end

endmodule